// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses, for each of the two ALU operands of a five-stage in-order pipeline, where the operand comes from: the value read from the register file in decode, the result waiting in the EX/MEM pipeline register, or the result waiting in the MEM/WB pipeline register. A source register number in execute is compared against the destination register of each of the two older instructions still in flight. An older instruction that writes that register supplies its result instead of the stale register file copy. When both older instructions match, the younger one supplies the result. Register zero is never bypassed, because it always reads as zero.

The block produces a 2-bit select for each operand and also drives the selected operand value through a thin multiplexer. A parameter registers both outputs for timing closure. With the register on, the select and the operand that belong to the inputs presented in one cycle appear after the next rising clock edge.

Top module: `opnd_bypass`

## Requirements
- R1: When the EX/MEM write enable is 1, its destination is nonzero and it equals an operand's source register, that operand's select is 2'b10 and the EX/MEM result is used.
- R2: When the MEM/WB write enable is 1, its destination is nonzero and it equals an operand's source register, and R1 does not apply to that operand, the select is 2'b01 and the MEM/WB result is used.
- R3: When both older stages write the same nonzero source register of an operand, the EX/MEM result wins and the select is 2'b10.
- R4: A destination of register 0 is never bypassed. A source of 0 gives select 2'b00 and the register file value, even when both write enables are 1 and both destinations are 0.
- R5: When no stage matches, or a matching stage has its write enable at 0, the select is 2'b00 and the operand is the register file value.
- R6: Each operand output equals the value of the source named by its select. The select value 2'b11 never occurs.
- R7: The two operands are resolved independently, so in the same cycle one may take EX/MEM and the other MEM/WB.
- R8: With OUT_REG=1, selects and operands appear one clock after their inputs. A synchronous active-high reset clears both selects to 2'b00 and both operands to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs_a | input | AW | Source register number of operand A in execute |
| ex_rs_b | input | AW | Source register number of operand B in execute |
| ex_rf_a | input | W | Register file value read for operand A |
| ex_rf_b | input | W | Register file value read for operand B |
| exm_we | input | 1 | EX/MEM register-write flag |
| exm_rd | input | AW | EX/MEM destination register number |
| exm_val | input | W | EX/MEM result |
| mwb_we | input | 1 | MEM/WB register-write flag |
| mwb_rd | input | AW | MEM/WB destination register number |
| mwb_val | input | W | MEM/WB result |
| sel_a | output | 2 | Select for operand A (00 register file, 10 EX/MEM, 01 MEM/WB) |
| sel_b | output | 2 | Select for operand B |
| opnd_a | output | W | Operand A after bypass |
| opnd_b | output | W | Operand B after bypass |

## Verification
The bench builds the block with the default register-number width of 5 and a 16-bit data width, with the output register enabled. That width keeps the data values small and easy to read in failure lines. The directed vectors cover register 0 on both destinations, equal destinations in both stages, and a set write enable with a mismatched destination. A random phase then draws register numbers from the range 0 to 3 only. This makes collisions between sources and destinations frequent, so priority, register-zero suppression and mixed per-operand selection occur many times. The one-cycle output register delay is checked on every item.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } bypass_src_e;
endpackage

// File: rtl/bypass_match.sv
module bypass_match
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          exm_we,
  input  logic [AW-1:0] exm_rd,
  input  logic          mwb_we,
  input  logic [AW-1:0] mwb_rd,
  output bypass_src_e   sel
);
  logic exm_hit;
  logic mwb_hit;

  // Register zero is never a bypass target.
  assign exm_hit = exm_we && (exm_rd != '0) && (exm_rd == src);
  assign mwb_hit = mwb_we && (mwb_rd != '0) && (mwb_rd == src);

  always_comb begin
    if (exm_hit)      sel = SRC_EXMEM;   // younger result first
    else if (mwb_hit) sel = SRC_MEMWB;
    else              sel = SRC_RF;
  end
endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import bypass_pkg::*;
#(
  parameter int W = 64
) (
  input  bypass_src_e  sel,
  input  logic [W-1:0] rf_val,
  input  logic [W-1:0] exm_val,
  input  logic [W-1:0] mwb_val,
  output logic [W-1:0] dout
);
  always_comb begin
    unique case (sel)
      SRC_EXMEM: dout = exm_val;
      SRC_MEMWB: dout = mwb_val;
      default:   dout = rf_val;
    endcase
  end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import bypass_pkg::*;
#(
  parameter int AW      = 5,
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ex_rs_a,
  input  logic [AW-1:0] ex_rs_b,
  input  logic [W-1:0]  ex_rf_a,
  input  logic [W-1:0]  ex_rf_b,
  input  logic          exm_we,
  input  logic [AW-1:0] exm_rd,
  input  logic [W-1:0]  exm_val,
  input  logic          mwb_we,
  input  logic [AW-1:0] mwb_rd,
  input  logic [W-1:0]  mwb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [W-1:0]  opnd_a,
  output logic [W-1:0]  opnd_b
);
  localparam int NOPS = 2;

  logic [AW-1:0] src   [NOPS];
  logic [W-1:0]  rfv   [NOPS];
  bypass_src_e   sel_c [NOPS];
  logic [W-1:0]  opd_c [NOPS];

  assign src[0] = ex_rs_a;
  assign src[1] = ex_rs_b;
  assign rfv[0] = ex_rf_a;
  assign rfv[1] = ex_rf_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bypass_match #(.AW(AW)) u_match (
      .src    (src[g]),
      .exm_we (exm_we),
      .exm_rd (exm_rd),
      .mwb_we (mwb_we),
      .mwb_rd (mwb_rd),
      .sel    (sel_c[g])
    );
    bypass_mux #(.W(W)) u_mux (
      .sel     (sel_c[g]),
      .rf_val  (rfv[g]),
      .exm_val (exm_val),
      .mwb_val (mwb_val),
      .dout    (opd_c[g])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_a  <= SRC_RF;
        sel_b  <= SRC_RF;
        opnd_a <= '0;
        opnd_b <= '0;
      end else begin
        sel_a  <= sel_c[0];
        sel_b  <= sel_c[1];
        opnd_a <= opd_c[0];
        opnd_b <= opd_c[1];
      end
    end
  end else begin : g_comb
    assign sel_a  = sel_c[0];
    assign sel_b  = sel_c[1];
    assign opnd_a = opd_c[0];
    assign opnd_b = opd_c[1];
  end
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int AW      = 5,
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ex_rs_a,
  input logic [AW-1:0] ex_rs_b,
  input logic [W-1:0]  ex_rf_a,
  input logic [W-1:0]  ex_rf_b,
  input logic          exm_we,
  input logic [AW-1:0] exm_rd,
  input logic [W-1:0]  exm_val,
  input logic          mwb_we,
  input logic [AW-1:0] mwb_rd,
  input logic [W-1:0]  mwb_val,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b
);
  // Inputs aligned with the outputs they produce.
  logic [AW-1:0] q_rs_a, q_rs_b, q_exm_rd, q_mwb_rd;
  logic [W-1:0]  q_rf_a, q_rf_b, q_exm_val, q_mwb_val;
  logic          q_exm_we, q_mwb_we;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        q_rs_a <= '0; q_rs_b <= '0; q_exm_rd <= '0; q_mwb_rd <= '0;
        q_rf_a <= '0; q_rf_b <= '0; q_exm_val <= '0; q_mwb_val <= '0;
        q_exm_we <= 1'b0; q_mwb_we <= 1'b0;
      end else begin
        q_rs_a <= ex_rs_a; q_rs_b <= ex_rs_b; q_exm_rd <= exm_rd; q_mwb_rd <= mwb_rd;
        q_rf_a <= ex_rf_a; q_rf_b <= ex_rf_b; q_exm_val <= exm_val; q_mwb_val <= mwb_val;
        q_exm_we <= exm_we; q_mwb_we <= mwb_we;
      end
    end
  end else begin : g_nodly
    assign q_rs_a = ex_rs_a;   assign q_rs_b = ex_rs_b;
    assign q_exm_rd = exm_rd;  assign q_mwb_rd = mwb_rd;
    assign q_rf_a = ex_rf_a;   assign q_rf_b = ex_rf_b;
    assign q_exm_val = exm_val; assign q_mwb_val = mwb_val;
    assign q_exm_we = exm_we;  assign q_mwb_we = mwb_we;
  end

  logic ea, eb, ma, mb;
  assign ea = q_exm_we && (q_exm_rd != '0) && (q_exm_rd == q_rs_a);
  assign eb = q_exm_we && (q_exm_rd != '0) && (q_exm_rd == q_rs_b);
  assign ma = q_mwb_we && (q_mwb_rd != '0) && (q_mwb_rd == q_rs_a);
  assign mb = q_mwb_we && (q_mwb_rd != '0) && (q_mwb_rd == q_rs_b);

  assert_ex_hit_a_R1: assert property (@(posedge clk) disable iff (rst) ea |-> sel_a == 2'b10);
  assert_ex_hit_b_R1: assert property (@(posedge clk) disable iff (rst) eb |-> sel_b == 2'b10);
  assert_mem_hit_a_R2: assert property (@(posedge clk) disable iff (rst) (ma && !ea) |-> sel_a == 2'b01);
  assert_mem_hit_b_R2: assert property (@(posedge clk) disable iff (rst) (mb && !eb) |-> sel_b == 2'b01);
  assert_zero_src_a_R4: assert property (@(posedge clk) disable iff (rst) (q_rs_a == '0) |-> (sel_a == 2'b00 && opnd_a == q_rf_a));
  assert_zero_src_b_R4: assert property (@(posedge clk) disable iff (rst) (q_rs_b == '0) |-> (sel_b == 2'b00 && opnd_b == q_rf_b));
  assert_no_hit_a_R5: assert property (@(posedge clk) disable iff (rst) (!ea && !ma) |-> (sel_a == 2'b00 && opnd_a == q_rf_a));
  assert_no_hit_b_R5: assert property (@(posedge clk) disable iff (rst) (!eb && !mb) |-> (sel_b == 2'b00 && opnd_b == q_rf_b));
  assert_val_exm_a_R6: assert property (@(posedge clk) disable iff (rst) (sel_a == 2'b10) |-> opnd_a == q_exm_val);
  assert_val_mwb_a_R6: assert property (@(posedge clk) disable iff (rst) (sel_a == 2'b01) |-> opnd_a == q_mwb_val);
  assert_val_exm_b_R6: assert property (@(posedge clk) disable iff (rst) (sel_b == 2'b10) |-> opnd_b == q_exm_val);
  assert_val_mwb_b_R6: assert property (@(posedge clk) disable iff (rst) (sel_b == 2'b01) |-> opnd_b == q_mwb_val);
  assert_no_code3_R6: assert property (@(posedge clk) disable iff (rst) (sel_a != 2'b11 && sel_b != 2'b11));
endmodule

bind opnd_bypass opnd_bypass_chk #(.AW(AW), .W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/opnd_bypass_tb.sv
module opnd_bypass_tb;
  localparam int AW = 5;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ex_rs_a, ex_rs_b, exm_rd, mwb_rd;
  logic [W-1:0]  ex_rf_a, ex_rf_b, exm_val, mwb_val;
  logic          exm_we, mwb_we;
  logic [1:0]    sel_a, sel_b;
  logic [W-1:0]  opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0]   sa, sb;
    logic [W-1:0] oa, ob;
    string        tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;   // 50 MHz

  opnd_bypass #(.AW(AW), .W(W), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .exm_we(exm_we), .exm_rd(exm_rd), .exm_val(exm_val),
    .mwb_we(mwb_we), .mwb_rd(mwb_rd), .mwb_val(mwb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Reference per R1..R5: 10 EX/MEM, 01 MEM/WB, 00 register file.
  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b10;
    if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [W-1:0] ref_val(logic [1:0] s, logic [W-1:0] rf);
    return (s == 2'b10) ? exm_val : (s == 2'b01) ? mwb_val : rf;
  endfunction

  task automatic drive(input logic [AW-1:0] ra, rb, input logic ew, input logic [AW-1:0] er,
                       input logic mw, input logic [AW-1:0] mr, input string tag);
    exp_t e;
    @(negedge clk);
    ex_rs_a = ra; ex_rs_b = rb; exm_we = ew; exm_rd = er; mwb_we = mw; mwb_rd = mr;
    ex_rf_a = W'($urandom); ex_rf_b = W'($urandom);
    exm_val = W'($urandom); mwb_val = W'($urandom);
    e.sa = ref_sel(ra); e.sb = ref_sel(rb);
    e.oa = ref_val(e.sa, ex_rf_a); e.ob = ref_val(e.sb, ex_rf_b);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: the result of inputs driven before a rising edge is sampled 5 ns after it (R8).
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() != 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (sel_a !== e.sa || sel_b !== e.sb || opnd_a !== e.oa || opnd_b !== e.ob) begin
          fails++;
          $display("FAIL %s: got sel %b/%b opnd %h/%h, expected sel %b/%b opnd %h/%h",
                   e.tag, sel_a, sel_b, opnd_a, opnd_b, e.sa, e.sb, e.oa, e.ob);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ex_rs_a = 0; ex_rs_b = 0; exm_rd = 0; mwb_rd = 0; exm_we = 0; mwb_we = 0;
    ex_rf_a = 16'h1111; ex_rf_b = 16'h2222; exm_val = 16'h3333; mwb_val = 16'h4444;
    repeat (3) @(posedge clk);
    #5;
    checks++;   // R8 reset state
    if (sel_a !== 2'b00 || sel_b !== 2'b00 || opnd_a !== '0 || opnd_b !== '0) begin
      fails++;
      $display("FAIL R8 reset: got %b/%b %h/%h, expected 00/00 0000/0000", sel_a, sel_b, opnd_a, opnd_b);
    end
    @(negedge clk); rst = 1'b0;

    drive(5'd3, 5'd7, 1, 5'd3, 0, 5'd0, "R1 ex hit on A");
    drive(5'd4, 5'd9, 1, 5'd9, 0, 5'd0, "R1 ex hit on B");
    drive(5'd6, 5'd1, 0, 5'd0, 1, 5'd6, "R2 mem hit on A");
    drive(5'd2, 5'd8, 1, 5'd5, 1, 5'd8, "R2 mem hit on B with ex mismatch");
    drive(5'd10, 5'd10, 1, 5'd10, 1, 5'd10, "R3 both stages same reg");
    drive(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, "R4 x0 never forwarded");
    drive(5'd0, 5'd12, 1, 5'd0, 1, 5'd12, "R4 x0 on A, mem on B");
    drive(5'd14, 5'd15, 0, 5'd14, 0, 5'd15, "R5 write enables clear");
    drive(5'd16, 5'd17, 1, 5'd18, 1, 5'd19, "R5 no match");
    drive(5'd20, 5'd21, 1, 5'd20, 1, 5'd21, "R7 A from ex, B from mem");
    drive(5'd22, 5'd23, 1, 5'd23, 1, 5'd22, "R7 A from mem, B from ex");
    drive(5'd31, 5'd31, 1, 5'd31, 0, 5'd31, "R6 top register ex value");
    for (int i = 0; i < 200; i++) begin
      drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)), 1'($urandom),
            AW'($urandom_range(0, 3)), 1'($urandom), AW'($urandom_range(0, 3)),
            "R6 R7 random mix");
    end
    @(posedge clk); #8;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule